// File: doc/BRIEF.md
# Burst Memory Command Sequencer

This block sits at the command input of a synchronous burst memory. On every rising clock edge it samples three control lines and classifies the cycle as a fresh address load, a step of the running burst, or an idle cycle. For each active cycle it produces a registered beat: the word address, a read/write flag and a single/double data rate flag.

The burst covers four consecutive words inside an aligned group. The lowest two address bits advance in either XOR (interleaved) or wrap-around (linear) order, picked by a static strap input. A continuation cycle takes its direction and rate from the load that started the burst.

The block also drives a registered bus high-impedance control. An idle cycle floats the bus one cycle later. An idle cycle that directly follows another idle cycle floats it two cycles later. Memory array, data paths and the double-rate clocking are outside this block.

Top module: `burst_seq`

## Requirements
- R1: With `cmd_hold`=0 at an edge (load), the outputs after that edge show `beat_valid`=1, `beat_addr`=`addr_in`, `beat_rd`=`cmd_dir` (1 = read, 0 = write) and `beat_sdr`=`cmd_rate` (1 = single rate, 0 = double rate).
- R2: With `cmd_hold`=1 and `cmd_dir`=1 while a burst is live (continue), `beat_valid`=1 and `beat_rd`/`beat_sdr` keep the values of the load that opened the burst. `cmd_rate` and `addr_in` have no effect in that cycle.
- R3: With `burst_mode`=1, the k-th beat of a burst (k = 0..3, k = 0 being the load) has low two address bits equal to the start bits XOR k.
- R4: With `burst_mode`=0, the k-th beat has low two address bits equal to (start + k) mod 4.
- R5: Address bits above bit 1 stay at their loaded value for the whole burst. After the fourth beat, further continues wrap within the same four-word group and keep the order.
- R6: With `cmd_hold`=1 and `cmd_dir`=0 at edge n, when the previous sample was not idle, the cycle is idle: `beat_valid`=0 after edge n and `bus_hiz`=1 after edge n+1.
- R7: When the previous sample had `cmd_hold`=1 and `cmd_dir`=0, a sample with `cmd_hold`=1 is idle whatever `cmd_dir` is: `beat_valid`=0 after edge n and `bus_hiz`=1 after edge n+2.
- R8: A continue request when no burst is live (after reset, or after any idle cycle without a load in between) is treated as idle with `beat_valid`=0.
- R9: A load or continue at edge n gives `bus_hiz`=0 after edge n+1. If a deferred float from R7 lands on the same edge, the float wins. After a deferred-only cycle the bus keeps its previous state.
- R10: During and right after reset, `beat_valid`=0, `beat_rd`=0, `beat_sdr`=0, `beat_addr`=0 and `bus_hiz`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_hold | input | 1 | 0 = load new address; 1 = continue or idle |
| cmd_dir | input | 1 | On load: 1 = read, 0 = write. When held: 1 = continue, 0 = idle |
| cmd_rate | input | 1 | On load: 1 = single data rate, 0 = double data rate |
| burst_mode | input | 1 | Static: 1 = interleaved order, 0 = linear order |
| addr_in | input | ADDR_W | Start address, sampled on load only |
| beat_addr | output | ADDR_W | Word address of the current beat |
| beat_valid | output | 1 | Current cycle is a load or continue beat |
| beat_rd | output | 1 | Beat direction, 1 = read |
| beat_sdr | output | 1 | Beat rate, 1 = single data rate |
| bus_hiz | output | 1 | Data bus high-impedance enable |

## Verification
The float from a second consecutive idle cycle lands two edges late. It can therefore meet the drive request of a load issued one cycle after that idle pair on the same edge. The bench provokes this with an idle, idle, load sequence and expects `bus_hiz` to read 1 after the edge where the two requests meet. A bit-exact model of the bus state runs over a long random command stream and catches any other overlap of deferred floats with immediate drives or floats.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   // bus effect class of a decoded cycle
   typedef enum logic [1:0] {
      CLS_ACT  = 2'd0,   // drive bus one cycle later
      CLS_NOP1 = 2'd1,   // float bus one cycle later
      CLS_NOP2 = 2'd2    // float bus two cycles later
   } bus_cls_t;

   typedef enum logic [1:0] {
      KIND_LOAD = 2'd0,
      KIND_CONT = 2'd1,
      KIND_IDLE = 2'd2
   } cyc_kind_t;
endpackage

// File: rtl/burst_decode.sv
module burst_decode
   import burst_seq_pkg::*;
(
   input  logic      cmd_hold,
   input  logic      cmd_dir,
   input  logic      prev_idle,
   input  logic      burst_live,
   output cyc_kind_t kind,
   output bus_cls_t  cls
);
   always_comb begin
      if (!cmd_hold) begin
         kind = KIND_LOAD;
         cls  = CLS_ACT;
      end else if (prev_idle) begin
         kind = KIND_IDLE;
         cls  = CLS_NOP2;
      end else if (cmd_dir && burst_live) begin
         kind = KIND_CONT;
         cls  = CLS_ACT;
      end else begin
         kind = KIND_IDLE;
         cls  = CLS_NOP1;
      end
   end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
   parameter int CNT_W = 2
) (
   input  logic             order_xor,
   input  logic [CNT_W-1:0] start_lo,
   input  logic [CNT_W-1:0] beat_idx,
   output logic [CNT_W-1:0] addr_lo
);
   logic [CNT_W-1:0] lin_lo;
   logic [CNT_W-1:0] xor_lo;

   generate
      if (CNT_W == 1) begin : g_one_bit
         assign lin_lo = start_lo ^ beat_idx;
      end else begin : g_multi_bit
         assign lin_lo = start_lo + beat_idx;
      end
   endgenerate

   assign xor_lo  = start_lo ^ beat_idx;
   assign addr_lo = order_xor ? xor_lo : lin_lo;
endmodule

// File: rtl/burst_hiz_ctl.sv
module burst_hiz_ctl
   import burst_seq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  bus_cls_t cls_in,
   output logic     bus_hiz
);
   bus_cls_t cls_q;
   bus_cls_t cls_qq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls_q   <= CLS_NOP2;
         cls_qq  <= CLS_ACT;
         bus_hiz <= 1'b1;
      end else begin
         cls_q  <= cls_in;
         cls_qq <= cls_q;
         if (cls_qq == CLS_NOP2)     bus_hiz <= 1'b1;
         else if (cls_q == CLS_NOP1) bus_hiz <= 1'b1;
         else if (cls_q == CLS_ACT)  bus_hiz <= 1'b0;
      end
   end

   // R6: single idle floats the bus one edge later
   a_r6_float_next: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_in == CLS_NOP1) |=> ##1 bus_hiz);
   // R7: repeated idle floats the bus two edges later
   a_r7_float_late: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_in == CLS_NOP2) |=> ##2 bus_hiz);
   // R9: an active cycle with no deferred float pending drives the bus
   a_r9_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_in == CLS_ACT && cls_q != CLS_NOP2) |=> ##1 !bus_hiz);
endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BURST_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_hold,
   input  logic              cmd_dir,
   input  logic              cmd_rate,
   input  logic              burst_mode,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] beat_addr,
   output logic              beat_valid,
   output logic              beat_rd,
   output logic              beat_sdr,
   output logic              bus_hiz
);
   localparam int CNT_W = $clog2(BURST_LEN);

   generate
      if ((1 << CNT_W) != BURST_LEN || CNT_W < 1) begin : g_bad_len
         $error("burst_seq: BURST_LEN must be a power of two, at least 2");
      end
      if (ADDR_W <= CNT_W) begin : g_bad_width
         $error("burst_seq: ADDR_W must exceed the burst index width");
      end
   endgenerate

   cyc_kind_t        kind;
   bus_cls_t         cls;
   logic             prev_idle;
   logic             burst_live;
   logic [CNT_W-1:0] start_lo;
   logic [CNT_W-1:0] beat_q;
   logic [CNT_W-1:0] beat_nxt;
   logic [CNT_W-1:0] addr_lo;

   burst_decode u_decode (
      .cmd_hold   (cmd_hold),
      .cmd_dir    (cmd_dir),
      .prev_idle  (prev_idle),
      .burst_live (burst_live),
      .kind       (kind),
      .cls        (cls)
   );

   assign beat_nxt = beat_q + 1'b1;

   burst_addr_gen #(.CNT_W(CNT_W)) u_addr (
      .order_xor (burst_mode),
      .start_lo  (start_lo),
      .beat_idx  (beat_nxt),
      .addr_lo   (addr_lo)
   );

   burst_hiz_ctl u_hiz (
      .clk     (clk),
      .rst_n   (rst_n),
      .cls_in  (cls),
      .bus_hiz (bus_hiz)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_idle  <= 1'b0;
         burst_live <= 1'b0;
         start_lo   <= '0;
         beat_q     <= '0;
         beat_addr  <= '0;
         beat_valid <= 1'b0;
         beat_rd    <= 1'b0;
         beat_sdr   <= 1'b0;
      end else begin
         prev_idle <= cmd_hold & ~cmd_dir;
         unique case (kind)
            KIND_LOAD: begin
               burst_live <= 1'b1;
               start_lo   <= addr_in[CNT_W-1:0];
               beat_q     <= '0;
               beat_addr  <= addr_in;
               beat_valid <= 1'b1;
               beat_rd    <= cmd_dir;
               beat_sdr   <= cmd_rate;
            end
            KIND_CONT: begin
               beat_q                <= beat_nxt;
               beat_addr[CNT_W-1:0]  <= addr_lo;
               beat_valid            <= 1'b1;
            end
            default: begin
               burst_live <= 1'b0;
               beat_valid <= 1'b0;
            end
         endcase
      end
   end

   // R1: load captures address and type
   a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_hold |=> beat_valid && beat_addr == $past(addr_in)
                    && beat_rd == $past(cmd_dir) && beat_sdr == $past(cmd_rate));
   // R2: continue keeps the burst type
   a_r2_keep_type: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == KIND_CONT) |=> beat_valid && $stable(beat_rd) && $stable(beat_sdr));
   // R5: upper address bits frozen during continue
   a_r5_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == KIND_CONT) |=> $stable(beat_addr[ADDR_W-1:CNT_W]));
   // R6: idle request gives no beat
   a_r6_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hold && !cmd_dir) |=> !beat_valid);
   // R8: continue with no live burst gives no beat
   a_r8_orphan: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hold && !burst_live) |=> !beat_valid);
endmodule

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_hold = 1'b1, cmd_dir = 1'b0, cmd_rate = 1'b0, burst_mode = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] beat_addr;
   logic          beat_valid, beat_rd, beat_sdr, bus_hiz;

   int n_run = 0;
   int n_fail = 0;

   // reference state
   logic          m_live, m_prev_idle, m_valid, m_rd, m_sdr, m_bus;
   logic [AW-1:0] m_addr;
   logic [1:0]    m_start, m_beat;
   int            m_p1, m_p2, m_kind;   // class: 0 act, 1 float next, 2 float late

   always #10 clk = ~clk;

   burst_seq #(.ADDR_W(AW), .BURST_LEN(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_hold(cmd_hold), .cmd_dir(cmd_dir),
      .cmd_rate(cmd_rate), .burst_mode(burst_mode), .addr_in(addr_in),
      .beat_addr(beat_addr), .beat_valid(beat_valid), .beat_rd(beat_rd),
      .beat_sdr(beat_sdr), .bus_hiz(bus_hiz)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_live = 0; m_prev_idle = 0; m_valid = 0; m_rd = 0; m_sdr = 0;
      m_bus = 1; m_addr = '0; m_start = 0; m_beat = 0; m_p1 = 2; m_p2 = 0;
   endtask

   task automatic model_edge(input logic h, d, r, input logic [AW-1:0] a);
      int cls;
      if (m_p2 == 2)      m_bus = 1;
      else if (m_p1 == 1) m_bus = 1;
      else if (m_p1 == 0) m_bus = 0;
      if (!h) begin
         cls = 0; m_kind = 0;
         m_live = 1; m_start = a[1:0]; m_beat = 0; m_addr = a;
         m_valid = 1; m_rd = d; m_sdr = r;
      end else if (m_prev_idle) begin
         cls = 2; m_kind = 3; m_live = 0; m_valid = 0;
      end else if (d && m_live) begin
         cls = 0; m_kind = 1;
         m_beat = m_beat + 2'd1;
         m_addr[1:0] = burst_mode ? (m_start ^ m_beat) : (m_start + m_beat);
         m_valid = 1;
      end else begin
         cls = 1; m_kind = 2; m_live = 0; m_valid = 0;
      end
      m_p2 = m_p1; m_p1 = cls;
      m_prev_idle = h & ~d;
   endtask

   task automatic compare();
      string t;
      case (m_kind)
         0: t = "R1";
         1: t = burst_mode ? "R3" : "R4";
         2: t = "R6";
         default: t = "R7";
      endcase
      chk(beat_valid == m_valid, t, "beat_valid", beat_valid, m_valid);
      if (m_valid) begin
         chk(beat_addr == m_addr, t, "beat_addr", beat_addr, m_addr);
         chk(beat_rd == m_rd, (m_kind == 1) ? "R2" : "R1", "beat_rd", beat_rd, m_rd);
         chk(beat_sdr == m_sdr, (m_kind == 1) ? "R2" : "R1", "beat_sdr", beat_sdr, m_sdr);
      end
      chk(bus_hiz == m_bus, "R9", "bus_hiz", bus_hiz, m_bus);
   endtask

   task automatic step(input logic h, d, r, input logic [AW-1:0] a);
      cmd_hold = h; cmd_dir = d; cmd_rate = r; addr_in = a;
      @(posedge clk);
      model_edge(h, d, r, a);
      @(negedge clk);
      compare();
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [AW-1:0] up;
      model_reset();
      repeat (3) @(negedge clk);
      // R10: reset values
      chk(beat_valid == 0, "R10", "beat_valid", beat_valid, 0);
      chk(beat_rd == 0 && beat_sdr == 0, "R10", "rd/sdr", {beat_rd, beat_sdr}, 0);
      chk(beat_addr == 0, "R10", "beat_addr", beat_addr, 0);
      chk(bus_hiz == 1, "R10", "bus_hiz", bus_hiz, 1);
      rst_n = 1'b1;

      // R8: continue with no burst after reset
      step(1, 1, 0, 8'h5A);
      chk(beat_valid == 0, "R8", "orphan continue after reset", beat_valid, 0);

      // exhaustive start/type/order sweep with wrap (R3 R4 R5 R2)
      for (int md = 0; md < 2; md++) begin
         burst_mode = md[0];
         for (int st = 0; st < 4; st++)
            for (int ty = 0; ty < 4; ty++) begin
               up = 8'($urandom) & 8'hFC;
               step(0, ty[0], ty[1], up | 8'(st));
               for (int k = 1; k < 7; k++) begin
                  step(1, 1, ~ty[1] ^ k[0], 8'($urandom));
                  chk(beat_addr[7:2] == up[7:2], "R5", "upper bits", beat_addr[7:2], up[7:2]);
                  chk(beat_addr[1:0] == (md[0] ? (2'(st) ^ 2'(k)) : 2'(st + k)),
                      md[0] ? "R3" : "R4", "beat low bits", beat_addr[1:0],
                      md[0] ? (2'(st) ^ 2'(k)) : 2'(st + k));
               end
               step(1, 0, 0, '0);
            end
      end

      // R7 then R8: idle, idle(dir=1), continue -> all idle
      step(0, 1, 1, 8'h40);
      step(1, 0, 0, '0);
      step(1, 1, 0, '0);
      chk(beat_valid == 0, "R7", "second idle with dir=1", beat_valid, 0);
      step(1, 1, 0, '0);
      chk(beat_valid == 0, "R8", "continue after idle", beat_valid, 0);

      // R9 collision: idle, idle, load -> float wins on the shared edge
      step(0, 0, 0, 8'h10);
      step(1, 0, 0, '0);
      step(1, 0, 0, '0);
      step(0, 1, 0, 8'h21);
      step(1, 1, 0, '0);
      chk(bus_hiz == 1, "R9", "deferred float beats drive", bus_hiz, 1);
      step(1, 1, 0, '0);
      chk(bus_hiz == 0, "R9", "drive after collision", bus_hiz, 0);

      // random command stream
      for (int i = 0; i < 4000; i++) begin
         if (i % 1000 == 0) burst_mode = 1'($urandom);
         step(($urandom % 4) != 0, 1'($urandom), 1'($urandom), 8'($urandom));
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule